// File: doc/BRIEF.md
# Video Level Offset with Saturation

This block conditions 8-bit luma and chroma samples on their way into a signed filter datapath. It then restores the filter's signed results to unsigned 8-bit video codes. On the way in, a control input can take the black level of 16 off luma and the mid-scale value of 128 off chroma. Luma then reaches the filter with black at zero, and chroma becomes a two's complement number centred on zero. On the way back, the luma and chroma offsets are always added again, whatever the control input says. Every result is clamped, so no unsigned code falls below 0 or rises above 254.

The two directions are independent streams. Each has its own valid strobe and one register stage. The filter sits between the conditioning output (`pre_*`) and the restoring input (`flt_*`) and is not part of this block. Intermediate sums are held in wide signed integers, so overflow is seen before the clamp is applied.

Top module: `vid_level_cond`

## Requirements
- R1: While reset is held, and in the first cycle after it, `pre_valid` and `out_valid` are 0 and every data output is 0.
- R2: With `remove_offset`=1, a valid luma input y gives `pre_luma` = max(y-16, 0), a signed value, one cycle later. Inputs 0 to 16 give 0.
- R3: With `remove_offset`=0, a valid luma input y gives `pre_luma` = min(y, 254) one cycle later.
- R4: With `remove_offset`=1, a valid chroma input c gives `pre_chroma` = min(c, 254) - 128 as two's complement one cycle later. Input 128 gives 0 and input 0 gives -128.
- R5: With `remove_offset`=0, a valid chroma input c gives `pre_chroma` = min(c, 254) one cycle later.
- R6: A valid filter luma result f (signed, `FILT_W` bits) gives `out_luma` = clamp(f+16, 0, 254) one cycle later, whatever the value of `remove_offset`.
- R7: A valid filter chroma result f gives `out_chroma` = clamp(f+128, 0, 254) one cycle later, whatever the value of `remove_offset`.
- R8: `pre_valid` is `in_valid` delayed by one cycle, and `out_valid` is `flt_valid` delayed by one cycle. Each valid output cycle carries exactly one result, in input order.
- R9: In a cycle where a stream's input valid is low, that stream's data outputs keep their previous values.
- R10: `out_luma` and `out_chroma` never exceed 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| remove_offset | input | 1 | 1: take the input offsets off before the filter |
| in_valid | input | 1 | Input sample strobe |
| in_luma | input | 8 | Unsigned luma sample |
| in_chroma | input | 8 | Unsigned chroma sample, mid-scale 128 |
| pre_valid | output | 1 | Conditioned sample strobe |
| pre_luma | output | 10 | Signed luma sent to the filter |
| pre_chroma | output | 10 | Signed chroma sent to the filter |
| flt_valid | input | 1 | Filter result strobe |
| flt_luma | input | 10 | Signed filtered luma |
| flt_chroma | input | 10 | Signed filtered chroma |
| out_valid | output | 1 | Restored sample strobe |
| out_luma | output | 8 | Unsigned luma, 0..254 |
| out_chroma | output | 8 | Unsigned chroma, 0..254 |

## Verification
The assertions assume that `remove_offset` is sampled on the same edge as the data it applies to. They also assume that filter results use the full signed `FILT_W`-bit range, with no value outside it. The stimulus changes the control bit only together with a driven sample. It draws filter values from the legal signed range, including both extremes and the points just either side of each clamp threshold. Idle gaps are placed between bursts so that the hold behaviour is exercised.

// File: rtl/vlo_pkg.sv
// Shared definitions for the video level offset block.
// Assumes callers pass bounds with lo <= hi.
package vlo_pkg;

    localparam int NCH       = 2;
    localparam int CH_LUMA   = 0;
    localparam int CH_CHROMA = 1;

    // Clamp a signed integer into [lo, hi].
    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/vlo_in_chan.sv
// Input conditioning for one channel. Optionally removes OFF from an
// unsigned sample and registers a signed, clamped value for the filter.
// SIGNED_OUT lets the result go negative (chroma); otherwise it is
// clamped at 0 (luma). Assumes FILT_W >= DATA_W + 1.
module vlo_in_chan #(
    parameter int DATA_W     = 8,
    parameter int FILT_W     = 10,
    parameter int OFF        = 16,
    parameter bit SIGNED_OUT = 1'b0,
    parameter int CODE_MAX   = 254
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     remove_offset,
    input  logic                     vld,
    input  logic [DATA_W-1:0]        x,
    output logic signed [FILT_W-1:0] q
);

    int                     lvl;
    int                     lo;
    int                     hi;
    logic signed [FILT_W-1:0] sat;

    // Subtract the offset when asked and pick the clamp window.
    always_comb begin
        lvl = int'(x) - (remove_offset ? OFF : 0);
        lo  = (remove_offset && SIGNED_OUT) ? -OFF : 0;
        hi  = CODE_MAX - ((remove_offset && SIGNED_OUT) ? OFF : 0);
        sat = FILT_W'(vlo_pkg::clamp_int(lvl, lo, hi));
    end

    // Capture a new conditioned sample on each valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (vld) q <= sat;
    end

    // R2/R4: a sample at the offset value reaches the filter as zero
    a_r2_offset_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vld) && $past(remove_offset) && ($past(x) == DATA_W'(OFF)))
        |-> (q == '0));

    // R9: no valid, no change
    a_r9_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vld)) |-> $stable(q));

    // R4: conditioned value stays inside the legal window
    a_r4_pre_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q) >= -OFF) && (int'(q) <= CODE_MAX));

endmodule

// File: rtl/vlo_out_chan.sv
// Output restoration for one channel. Always adds OFF to the signed filter
// result and registers it clamped to 0..CODE_MAX. Assumes the result uses
// the full signed FILT_W range.
module vlo_out_chan #(
    parameter int DATA_W   = 8,
    parameter int FILT_W   = 10,
    parameter int OFF      = 16,
    parameter int CODE_MAX = 254
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     vld,
    input  logic signed [FILT_W-1:0] f,
    output logic [DATA_W-1:0]        q
);

    logic [DATA_W-1:0] sat;

    // Restore the offset and clamp into the unsigned code range.
    always_comb begin
        sat = DATA_W'(vlo_pkg::clamp_int(int'(f) + OFF, 0, CODE_MAX));
    end

    // Capture a restored sample on each valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (vld) q <= sat;
    end

    // R10: restored code never exceeds the ceiling
    a_r10_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        q <= DATA_W'(CODE_MAX));

    // R6/R7: a zero filter result restores to the offset value
    a_r6_zero_to_offset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vld) && ($past(f) == '0)) |-> (q == DATA_W'(OFF)));

    // R9: no valid, no change
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(vld)) |-> $stable(q));

endmodule

// File: rtl/vid_level_cond.sv
// Video level conditioning around a signed filter. The input side can remove
// the luma black level and the chroma mid-scale. The output side always adds
// them back, with clamping. Each direction is one register stage with a
// matching valid delay.
module vid_level_cond #(
    parameter int DATA_W     = 8,
    parameter int FILT_W     = 10,
    parameter int LUMA_BLACK = 16,
    parameter int CHROMA_MID = 128,
    parameter int CODE_MAX   = 254
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     remove_offset,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_luma,
    input  logic [DATA_W-1:0]        in_chroma,
    output logic                     pre_valid,
    output logic signed [FILT_W-1:0] pre_luma,
    output logic signed [FILT_W-1:0] pre_chroma,
    input  logic                     flt_valid,
    input  logic signed [FILT_W-1:0] flt_luma,
    input  logic signed [FILT_W-1:0] flt_chroma,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_luma,
    output logic [DATA_W-1:0]        out_chroma
);

    localparam int NCH = vlo_pkg::NCH;

    logic [DATA_W-1:0]        in_bus  [NCH];
    logic signed [FILT_W-1:0] pre_bus [NCH];
    logic signed [FILT_W-1:0] flt_bus [NCH];
    logic [DATA_W-1:0]        out_bus [NCH];

    assign in_bus[vlo_pkg::CH_LUMA]    = in_luma;
    assign in_bus[vlo_pkg::CH_CHROMA]  = in_chroma;
    assign flt_bus[vlo_pkg::CH_LUMA]   = flt_luma;
    assign flt_bus[vlo_pkg::CH_CHROMA] = flt_chroma;
    assign pre_luma   = pre_bus[vlo_pkg::CH_LUMA];
    assign pre_chroma = pre_bus[vlo_pkg::CH_CHROMA];
    assign out_luma   = out_bus[vlo_pkg::CH_LUMA];
    assign out_chroma = out_bus[vlo_pkg::CH_CHROMA];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int OFF = (g == vlo_pkg::CH_LUMA) ? LUMA_BLACK : CHROMA_MID;
        localparam bit SGN = (g == vlo_pkg::CH_CHROMA);

        vlo_in_chan #(
            .DATA_W(DATA_W), .FILT_W(FILT_W), .OFF(OFF),
            .SIGNED_OUT(SGN), .CODE_MAX(CODE_MAX)
        ) in_i (
            .clk(clk), .rst_n(rst_n), .remove_offset(remove_offset),
            .vld(in_valid), .x(in_bus[g]), .q(pre_bus[g])
        );

        vlo_out_chan #(
            .DATA_W(DATA_W), .FILT_W(FILT_W), .OFF(OFF), .CODE_MAX(CODE_MAX)
        ) out_i (
            .clk(clk), .rst_n(rst_n), .vld(flt_valid),
            .f(flt_bus[g]), .q(out_bus[g])
        );
    end

    // Delay each valid strobe to stay aligned with its data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            pre_valid <= in_valid;
            out_valid <= flt_valid;
        end
    end

    // R8: conditioning strobe trails the input strobe by one cycle
    a_r8_pre_valid_align: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pre_valid == $past(in_valid)));

    // R8: restore strobe trails the filter strobe by one cycle
    a_r8_out_valid_align: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(flt_valid)));

endmodule

// File: tb/vid_level_cond_tb_top.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares.
module vid_level_cond_tb_top;

    localparam int DW = 8;
    localparam int FW = 10;

    typedef struct {
        int    l;
        int    c;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic remove_offset = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_luma = '0;
    logic [DW-1:0] in_chroma = '0;
    logic pre_valid;
    logic signed [FW-1:0] pre_luma;
    logic signed [FW-1:0] pre_chroma;
    logic flt_valid = 1'b0;
    logic signed [FW-1:0] flt_luma = '0;
    logic signed [FW-1:0] flt_chroma = '0;
    logic out_valid;
    logic [DW-1:0] out_luma;
    logic [DW-1:0] out_chroma;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    exp_t q_pre[$];
    exp_t q_out[$];
    exp_t last_pre;
    exp_t last_out;
    bit have_pre = 1'b0;
    bit have_out = 1'b0;

    always #10 clk = ~clk;

    vid_level_cond dut_i (
        .clk(clk), .rst_n(rst_n), .remove_offset(remove_offset),
        .in_valid(in_valid), .in_luma(in_luma), .in_chroma(in_chroma),
        .pre_valid(pre_valid), .pre_luma(pre_luma), .pre_chroma(pre_chroma),
        .flt_valid(flt_valid), .flt_luma(flt_luma), .flt_chroma(flt_chroma),
        .out_valid(out_valid), .out_luma(out_luma), .out_chroma(out_chroma)
    );

    function automatic int clampb(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one input sample, expected conditioning result queued.
    task automatic send_pix(int y, int c, bit rm);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_luma = DW'(y);
        in_chroma = DW'(c);
        remove_offset = rm;
        e.l = rm ? ((y > 16) ? y - 16 : 0) : ((y > 254) ? 254 : y);
        e.c = ((c > 254) ? 254 : c) - (rm ? 128 : 0);
        e.tag = rm ? "R2/R4" : "R3/R5";
        q_pre.push_back(e);
    endtask

    task automatic idle_in(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_luma = DW'($urandom);
            in_chroma = DW'($urandom);
        end
    endtask

    // Driver: one filter result, expected restored result queued.
    task automatic send_flt(int fl, int fc);
        exp_t e;
        @(negedge clk);
        flt_valid = 1'b1;
        flt_luma = FW'(fl);
        flt_chroma = FW'(fc);
        e.l = clampb(fl + 16, 0, 254);
        e.c = clampb(fc + 128, 0, 254);
        e.tag = "R6/R7/R10";
        q_out.push_back(e);
    endtask

    task automatic idle_flt(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            flt_valid = 1'b0;
            flt_luma = FW'($urandom);
            flt_chroma = FW'($urandom);
        end
    endtask

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (pre_valid) begin
                if (q_pre.size() == 0) begin
                    chk("R8", "unexpected pre_valid", 1, 0);
                end else begin
                    last_pre = q_pre.pop_front();
                    have_pre = 1'b1;
                    chk(last_pre.tag, "pre_luma", int'(pre_luma), last_pre.l);
                    chk(last_pre.tag, "pre_chroma", int'(pre_chroma), last_pre.c);
                end
            end else if (have_pre) begin
                chk("R9", "pre_luma hold", int'(pre_luma), last_pre.l);
                chk("R9", "pre_chroma hold", int'(pre_chroma), last_pre.c);
            end
            if (out_valid) begin
                if (q_out.size() == 0) begin
                    chk("R8", "unexpected out_valid", 1, 0);
                end else begin
                    last_out = q_out.pop_front();
                    have_out = 1'b1;
                    chk(last_out.tag, "out_luma", int'(out_luma), last_out.l);
                    chk(last_out.tag, "out_chroma", int'(out_chroma), last_out.c);
                end
            end else if (have_out) begin
                chk("R9", "out_luma hold", int'(out_luma), last_out.l);
                chk("R9", "out_chroma hold", int'(out_chroma), last_out.c);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ys[8];
        int cs[8];
        int fs[14];
        ys = '{0, 15, 16, 17, 128, 235, 254, 255};
        cs = '{0, 1, 127, 128, 129, 240, 254, 255};
        fs = '{-512, -300, -129, -128, -127, -17, -16, 0, 100, 126, 127, 238, 239, 511};

        // R1: reset state, held and first cycle after release
        repeat (3) @(negedge clk);
        chk("R1", "pre_valid in reset", int'(pre_valid), 0);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pre_valid after reset", int'(pre_valid), 0);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        chk("R1", "pre_luma after reset", int'(pre_luma), 0);
        chk("R1", "pre_chroma after reset", int'(pre_chroma), 0);
        chk("R1", "out_luma after reset", int'(out_luma), 0);
        chk("R1", "out_chroma after reset", int'(out_chroma), 0);
        mon_en = 1'b1;

        // R2..R5: corner values in both control settings
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 8; i++) send_pix(ys[i], cs[i], m[0]);
            idle_in(3);
        end
        // R2..R5, R9: random values, control toggled, gaps in between
        for (int i = 0; i < 60; i++) begin
            send_pix(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 1'($urandom));
            if ($urandom_range(0, 3) == 0) idle_in(int'($urandom_range(1, 3)));
        end
        idle_in(3);

        // R6, R7, R10: thresholds with the control bit toggling meanwhile
        for (int i = 0; i < 14; i++) begin
            send_flt(fs[i], fs[13 - i]);
            remove_offset = i[0];
        end
        idle_flt(3);

        // R8: both streams running at once with independent gaps
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    send_pix(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 1'($urandom));
                    if ($urandom_range(0, 2) == 0) idle_in(1);
                end
                idle_in(2);
            end
            begin
                for (int i = 0; i < 40; i++) begin
                    send_flt(int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512);
                    if ($urandom_range(0, 3) == 0) idle_flt(2);
                end
                idle_flt(2);
            end
        join
        idle_in(3);

        // R8: every queued result must have appeared
        chk("R8", "pending conditioned results", q_pre.size(), 0);
        chk("R8", "pending restored results", q_out.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule